// File: doc/BRIEF.md
# System Control Coprocessor Register Block

This block sits on a processor core's coprocessor port and provides a small bank of eight 32-bit control registers. The core reaches them only through register-transfer requests: one kind moves a register value to the core, the other moves a core value into a register. The register is selected by a 4-bit register-number field taken from the transfer instruction. Requests for memory transfers or data operations are refused with a cannot-handle answer, so the core takes its undefined-instruction trap. A second, debug-side port reads and writes the same registers directly by index.

Slot 0 is a hard-wired identification word. Slot 1 is the configuration register. Its bits 7:4 drive four live core-mode outputs: program address width, data address width, abort timing and byte order. These bits load from four strap pins at reset. Any write to slot 1 also raises a one-cycle re-evaluate pulse, which tells the core to pick up its new configuration. Slots 2 to 7 are plain storage.

Top module: `scc_regs`

## Requirements
- R1: While reset is held, slot 1 loads `{24'b0, strap_big_endian, strap_late_abort, strap_data32, strap_prog32, 4'b0}`, slots 2 to 7 clear to zero, the four mode outputs equal their straps, and `mode_reeval`, `resp_valid`, `resp_done` and `resp_cant` are low.
- R2: A request with `req_op`=0 (register to core) returns the slot whose index is `req_field & 3'b111` on `resp_rdata`. Bit 3 of the field is ignored.
- R3: A request with `req_op`=1 (core to register) stores `req_wdata` into slot `req_field & 3'b111`. Slots 2 to 7 then read back the last value written.
- R4: Slot 0 always reads 32'h41440110 on both ports, whatever has been written to it.
- R5: `mode_prog32`, `mode_data32`, `mode_late_abort` and `mode_big_endian` equal bits 4, 5, 6 and 7 of slot 1. They take a written value in the cycle after the write and change at no other time. Slot 1 reads back the whole written word, including bits 3:0.
- R6: `mode_reeval` is high for exactly the one cycle after any write to slot 1 from either port, even when the value written is unchanged, and it is low in every other cycle.
- R7: A request with `req_op`=2 (memory transfer) or `req_op`=3 (data operation) answers with `resp_cant` high, `resp_done` low and `resp_rdata` zero, and it changes no register.
- R8: Every request is answered exactly once, in the cycle after the request is accepted. In an answer exactly one of `resp_done` and `resp_cant` is high. There is no answer without a request, and back-to-back requests get back-to-back answers.
- R9: `dbg_rdata` shows the slot selected by `dbg_idx` combinationally for indices 0 to 7 and shows zero for indices 8 to 15. A debug write with index 8 to 15 changes nothing and raises no pulse.
- R10: When both ports write in the same cycle, the core write wins if the two writes target the same slot. If they target different slots, both writes take effect.
- R11: A core read in the same cycle as a write to the same slot returns the value the slot held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_prog32 | input | 1 | Reset value of the program-width mode bit |
| strap_data32 | input | 1 | Reset value of the data-width mode bit |
| strap_late_abort | input | 1 | Reset value of the abort-timing mode bit |
| strap_big_endian | input | 1 | Reset value of the byte-order mode bit |
| req_valid | input | 1 | Coprocessor request present this cycle |
| req_op | input | 2 | 0 to core, 1 from core, 2 memory transfer, 3 data operation |
| req_field | input | 4 | Register-number field of the instruction |
| req_wdata | input | 32 | Core value for a register write |
| resp_valid | output | 1 | Answer present this cycle |
| resp_done | output | 1 | Request completed |
| resp_cant | output | 1 | Request refused |
| resp_rdata | output | 32 | Register value for a read answer, else zero |
| dbg_we | input | 1 | Debug write strobe |
| dbg_idx | input | 4 | Debug register index for both read and write |
| dbg_wdata | input | 32 | Debug write value |
| dbg_rdata | output | 32 | Debug read value |
| mode_prog32 | output | 1 | 32-bit program address space select |
| mode_data32 | output | 1 | 32-bit data address space select |
| mode_late_abort | output | 1 | Late abort timing select |
| mode_big_endian | output | 1 | Big-endian select |
| mode_reeval | output | 1 | One-cycle configuration re-evaluate pulse |

## Verification
The bench goes after the places where the index is narrower than it looks. A field with bit 3 set must reach slot 5, not fall through to zero. A debug write to index 9 must not alias onto slot 1; a design that truncated there would overwrite the configuration and pulse `mode_reeval`. It writes slot 0 from both ports and expects the identification word back, which catches any design that stores into slot 0. It also writes slot 1 twice with the same value, where a design that pulsed only on a change would stay silent. Same-cycle collisions show up a port priority reversed or a read forwarded from a concurrent write. Refused requests must still answer in the following cycle and must leave slot 2 untouched.

// File: rtl/scc_pkg.sv
package scc_pkg;

  localparam int unsigned SCC_DW      = 32;
  localparam int unsigned SCC_FIELD_W = 4;
  localparam int unsigned MODE_LSB    = 4;

  typedef enum logic [1:0] {
    OP_TO_CORE   = 2'd0,
    OP_FROM_CORE = 2'd1,
    OP_MEM_XFER  = 2'd2,
    OP_DATA_OP   = 2'd3
  } scc_op_e;

  // Packed so that the member order matches bits 7:4 of the config word.
  typedef struct packed {
    logic big_endian;
    logic late_abort;
    logic data32;
    logic prog32;
  } scc_mode_t;

  // Mode field carried by a configuration word.
  function automatic scc_mode_t f_mode_of(input logic [SCC_DW-1:0] w);
    return scc_mode_t'(4'(w >> MODE_LSB));
  endfunction

  // Configuration word loaded while reset is held.
  function automatic logic [SCC_DW-1:0] f_cfg_reset(input scc_mode_t m);
    return SCC_DW'(m) << MODE_LSB;
  endfunction

endpackage

// File: rtl/scc_decode.sv
module scc_decode
  import scc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [1:0]             req_op,
  input  logic [SCC_FIELD_W-1:0] req_field,
  output logic                   dec_rd,
  output logic                   dec_wr,
  output logic                   dec_cant,
  output logic [IDX_W-1:0]       dec_idx
);

  scc_op_e op;
  assign op = scc_op_e'(req_op);

  // Field masked down to the implemented slot count.
  assign dec_idx  = IDX_W'(req_field & SCC_FIELD_W'(NUM_REGS - 1));
  assign dec_rd   = req_valid && (op == OP_TO_CORE);
  assign dec_wr   = req_valid && (op == OP_FROM_CORE);
  assign dec_cant = req_valid && ((op == OP_MEM_XFER) || (op == OP_DATA_OP));

  // R8: an accepted request falls into exactly one class
  p_one_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({dec_rd, dec_wr, dec_cant}) == 1);

  p_no_class_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(dec_rd || dec_wr || dec_cant));

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned DBG_IDX_W = 4,
  parameter int unsigned CFG_SLOT  = 1,
  parameter logic [SCC_DW-1:0] ID_VALUE = 32'h4144_0110
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scc_mode_t            strap_mode,
  input  logic                 core_we,
  input  logic [IDX_W-1:0]     core_idx,
  input  logic [SCC_DW-1:0]    core_wdata,
  output logic [SCC_DW-1:0]    core_rdata,
  input  logic                 dbg_we,
  input  logic [DBG_IDX_W-1:0] dbg_idx,
  input  logic [SCC_DW-1:0]    dbg_wdata,
  output logic [SCC_DW-1:0]    dbg_rdata,
  output logic [SCC_DW-1:0]    cfg_word,
  output logic                 cfg_wr_evt
);

  logic [NUM_REGS-1:0][SCC_DW-1:0] slot_val;
  logic [NUM_REGS-1:0]             core_hit;
  logic [NUM_REGS-1:0]             dbg_hit;
  logic                            dbg_in_range;
  logic [IDX_W-1:0]                dbg_slot;
  logic [SCC_DW-1:0]               cfg_rst_word;

  assign dbg_in_range = (dbg_idx < DBG_IDX_W'(NUM_REGS));
  assign dbg_slot     = IDX_W'(dbg_idx);
  assign cfg_rst_word = f_cfg_reset(strap_mode);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign core_hit[g] = core_we && (core_idx == IDX_W'(g));
    assign dbg_hit[g]  = dbg_we && dbg_in_range && (dbg_slot == IDX_W'(g));

    if (g == 0) begin : g_id
      // Identification slot: no storage, writes have nowhere to land.
      assign slot_val[g] = ID_VALUE;
    end else begin : g_store
      logic [SCC_DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= (g == CFG_SLOT) ? cfg_rst_word : '0;
        end else if (core_hit[g]) begin
          q <= core_wdata;
        end else if (dbg_hit[g]) begin
          q <= dbg_wdata;
        end
      end
      assign slot_val[g] = q;
    end
  end

  assign core_rdata = slot_val[core_idx];
  assign dbg_rdata  = dbg_in_range ? slot_val[dbg_slot] : '0;
  assign cfg_word   = slot_val[CFG_SLOT];
  assign cfg_wr_evt = core_hit[CFG_SLOT] || dbg_hit[CFG_SLOT];

  p_core_hit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_hit));

  // R9: an out-of-range debug write alone leaves every slot as it was
  p_dbg_oob_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && !dbg_in_range && !core_we) |=> $stable(slot_val));

  // R10: the core write wins a same-slot collision
  p_core_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && dbg_we && dbg_in_range && (dbg_slot == core_idx) && (core_idx != '0))
    |=> slot_val[$past(core_idx)] == $past(core_wdata));

  // R4: debug read of slot 0 gives the identification word
  p_dbg_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_idx == '0) |-> dbg_rdata == ID_VALUE);

endmodule

// File: rtl/scc_mode_out.sv
module scc_mode_out
  import scc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SCC_DW-1:0] cfg_word,
  input  logic              cfg_wr_evt,
  output scc_mode_t         mode_o,
  output logic              reeval_o
);

  logic reeval_q;

  assign mode_o = f_mode_of(cfg_word);

  always_ff @(posedge clk) begin
    if (!rst_n) reeval_q <= 1'b0;
    else        reeval_q <= cfg_wr_evt;
  end

  assign reeval_o = reeval_q;

  // R5: modes move only after a configuration write
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr_evt) |-> $stable(mode_o));

  // R6: the pulse follows every configuration write
  p_pulse_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_evt |=> reeval_o);

  p_pulse_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reeval_o |-> $past(cfg_wr_evt));

endmodule

// File: rtl/scc_regs.sv
module scc_regs
  import scc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned CFG_SLOT = 1,
  parameter logic [31:0] ID_VALUE = 32'h4144_0110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_prog32,
  input  logic        strap_data32,
  input  logic        strap_late_abort,
  input  logic        strap_big_endian,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [3:0]  req_field,
  input  logic [31:0] req_wdata,
  output logic        resp_valid,
  output logic        resp_done,
  output logic        resp_cant,
  output logic [31:0] resp_rdata,
  input  logic        dbg_we,
  input  logic [3:0]  dbg_idx,
  input  logic [31:0] dbg_wdata,
  output logic [31:0] dbg_rdata,
  output logic        mode_prog32,
  output logic        mode_data32,
  output logic        mode_late_abort,
  output logic        mode_big_endian,
  output logic        mode_reeval
);

  localparam int unsigned IDX_W     = $clog2(NUM_REGS);
  localparam int unsigned DBG_IDX_W = 4;

  logic              dec_rd, dec_wr, dec_cant;
  logic [IDX_W-1:0]  dec_idx;
  logic [SCC_DW-1:0] core_rdata, cfg_word;
  logic              cfg_wr_evt;
  scc_mode_t         strap_mode, mode;

  logic              resp_valid_q, resp_cant_q;
  logic [SCC_DW-1:0] resp_rdata_q;

  assign strap_mode = '{big_endian: strap_big_endian, late_abort: strap_late_abort,
                        data32: strap_data32, prog32: strap_prog32};

  scc_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_field(req_field), .dec_rd(dec_rd), .dec_wr(dec_wr),
    .dec_cant(dec_cant), .dec_idx(dec_idx)
  );

  scc_regfile #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DBG_IDX_W(DBG_IDX_W),
    .CFG_SLOT(CFG_SLOT), .ID_VALUE(ID_VALUE)
  ) u_regfile (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode),
    .core_we(dec_wr), .core_idx(dec_idx), .core_wdata(req_wdata),
    .core_rdata(core_rdata), .dbg_we(dbg_we), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .cfg_word(cfg_word), .cfg_wr_evt(cfg_wr_evt)
  );

  scc_mode_out u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_wr_evt(cfg_wr_evt),
    .mode_o(mode), .reeval_o(mode_reeval)
  );

  // Single-handshake answer, registered one cycle after the request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_cant_q  <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      resp_valid_q <= req_valid;
      resp_cant_q  <= dec_cant;
      resp_rdata_q <= dec_rd ? core_rdata : '0;
    end
  end

  assign resp_valid      = resp_valid_q;
  assign resp_cant       = resp_cant_q;
  assign resp_done       = resp_valid_q && !resp_cant_q;
  assign resp_rdata      = resp_rdata_q;
  assign mode_prog32     = mode.prog32;
  assign mode_data32     = mode.data32;
  assign mode_late_abort = mode.late_abort;
  assign mode_big_endian = mode.big_endian;

  // R8: answer in the next cycle, and only then
  p_resp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  p_resp_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid));

  p_done_xor_cant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot({resp_done, resp_cant}));

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_done || resp_cant));

  // R7: refused requests carry no data
  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[1]) |=> (resp_cant && resp_rdata == '0));

  // R4: core read of slot 0 gives the identification word
  p_core_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && req_field[IDX_W-1:0] == '0) |=> resp_rdata == ID_VALUE);

endmodule

// File: tb/scc_regs_bench.sv
`timescale 1ns/1ps
module scc_regs_bench;

  localparam logic [31:0] ID_WORD = 32'h4144_0110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        strap_prog32 = 1'b0, strap_data32 = 1'b1;
  logic        strap_late_abort = 1'b0, strap_big_endian = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [3:0]  req_field = 4'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        resp_valid, resp_done, resp_cant;
  logic [31:0] resp_rdata;
  logic        dbg_we = 1'b0;
  logic [3:0]  dbg_idx = 4'd0;
  logic [31:0] dbg_wdata = 32'd0;
  logic [31:0] dbg_rdata;
  logic        mode_prog32, mode_data32, mode_late_abort, mode_big_endian, mode_reeval;

  scc_regs u_scc_regs (
    .clk(clk), .rst_n(rst_n),
    .strap_prog32(strap_prog32), .strap_data32(strap_data32),
    .strap_late_abort(strap_late_abort), .strap_big_endian(strap_big_endian),
    .req_valid(req_valid), .req_op(req_op), .req_field(req_field), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_done(resp_done), .resp_cant(resp_cant),
    .resp_rdata(resp_rdata), .dbg_we(dbg_we), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .mode_prog32(mode_prog32), .mode_data32(mode_data32),
    .mode_late_abort(mode_late_abort), .mode_big_endian(mode_big_endian),
    .mode_reeval(mode_reeval)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] model [8];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modes();
    return {28'd0, mode_big_endian, mode_late_abort, mode_data32, mode_prog32};
  endfunction

  // One core request; returns after the answer cycle's falling edge.
  task automatic core_op(input logic [1:0] op, input logic [3:0] field, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_field = field; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic dbg_write(input logic [3:0] idx, input logic [31:0] wd);
    @(negedge clk);
    dbg_we = 1'b1; dbg_idx = idx; dbg_wdata = wd;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic dbg_peek(input logic [3:0] idx, output logic [31:0] v);
    dbg_idx = idx;
    #0.5;
    v = dbg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 modes after reset", modes(), 32'h0000_000A);
    check("R1 no pulse", {31'd0, mode_reeval}, 32'd0);
    check("R1 no answer", {29'd0, resp_valid, resp_done, resp_cant}, 32'd0);
    dbg_peek(4'd1, v); check("R1 slot1 strap load", v, 32'h0000_00A0);
    for (int i = 2; i < 8; i++) begin
      dbg_peek(4'(i), v); check("R1 slot clear", v, 32'd0);
    end
    model[1] = 32'h0000_00A0;
    for (int i = 2; i < 8; i++) model[i] = 32'd0;
  endtask

  task automatic t_core_rw();
    for (int i = 2; i < 8; i++) begin
      model[i] = (32'h1357_9BDF * i) ^ 32'hA5A5_0F0F;
      core_op(2'd1, 4'(i), model[i]);
      check("R3 write done", {30'd0, resp_done, resp_cant}, 32'd2);
      check("R6 no pulse off slot1", {31'd0, mode_reeval}, 32'd0);
    end
    for (int i = 7; i >= 2; i--) begin
      core_op(2'd0, 4'(i), 32'hFFFF_FFFF);
      check("R3 readback", resp_rdata, model[i]);
      check("R2 read done", {30'd0, resp_done, resp_cant}, 32'd2);
    end
  endtask

  task automatic t_index_mask();
    model[5] = 32'hC0DE_0005;
    core_op(2'd1, 4'hD, model[5]);
    core_op(2'd0, 4'h5, 32'd0);
    check("R2 bit3 of field ignored on write", resp_rdata, model[5]);
    core_op(2'd0, 4'hA, 32'd0);
    check("R2 bit3 of field ignored on read", resp_rdata, model[2]);
  endtask

  task automatic t_id();
    logic [31:0] v;
    core_op(2'd1, 4'd0, 32'hDEAD_BEEF);
    core_op(2'd0, 4'd0, 32'd0);
    check("R4 core read id", resp_rdata, ID_WORD);
    dbg_write(4'd0, 32'h0BAD_F00D);
    dbg_peek(4'd0, v); check("R4 debug read id", v, ID_WORD);
    core_op(2'd0, 4'h8, 32'd0);
    check("R4 id via aliased field", resp_rdata, ID_WORD);
  endtask

  task automatic t_cfg();
    core_op(2'd1, 4'd1, 32'h0000_005F);
    check("R5 modes after core write", modes(), 32'h5);
    check("R6 pulse after core write", {31'd0, mode_reeval}, 32'd1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, mode_reeval}, 32'd0);
    core_op(2'd0, 4'd1, 32'd0);
    check("R5 slot1 full readback", resp_rdata, 32'h0000_005F);
    dbg_write(4'd1, 32'hFFFF_FF30);
    check("R5 modes after debug write", modes(), 32'h3);
    check("R6 pulse after debug write", {31'd0, mode_reeval}, 32'd1);
    dbg_write(4'd1, 32'hFFFF_FF30);
    check("R6 pulse on unchanged value", {31'd0, mode_reeval}, 32'd1);
    check("R5 modes held", modes(), 32'h3);
    model[1] = 32'hFFFF_FF30;
  endtask

  task automatic t_cant();
    logic [31:0] v;
    core_op(2'd2, 4'd2, 32'h1111_1111);
    check("R7 memory transfer refused", {29'd0, resp_valid, resp_done, resp_cant}, 32'h5);
    check("R7 no data", resp_rdata, 32'd0);
    core_op(2'd3, 4'd2, 32'h2222_2222);
    check("R7 data op refused", {29'd0, resp_valid, resp_done, resp_cant}, 32'h5);
    dbg_peek(4'd2, v); check("R7 slot unchanged", v, model[2]);
  endtask

  task automatic t_dbg_oob();
    logic [31:0] v;
    dbg_write(4'd9, 32'h0000_00F0);
    check("R9 no pulse on oob write", {31'd0, mode_reeval}, 32'd0);
    check("R9 modes unchanged", modes(), 32'h3);
    dbg_peek(4'd9, v); check("R9 oob read zero", v, 32'd0);
    dbg_peek(4'd15, v); check("R9 oob read zero top", v, 32'd0);
    for (int i = 1; i < 8; i++) begin
      dbg_peek(4'(i), v); check("R9 slots unchanged", v, model[i]);
    end
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_field = 4'd4; req_wdata = 32'hAAAA_0004;
    dbg_we = 1'b1; dbg_idx = 4'd4; dbg_wdata = 32'hBBBB_0004;
    @(negedge clk);
    req_valid = 1'b0; dbg_we = 1'b0;
    model[4] = 32'hAAAA_0004;
    dbg_peek(4'd4, v); check("R10 core wins same slot", v, model[4]);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_field = 4'd6; req_wdata = 32'h6666_6666;
    dbg_we = 1'b1; dbg_idx = 4'd7; dbg_wdata = 32'h7777_7777;
    @(negedge clk);
    req_valid = 1'b0; dbg_we = 1'b0;
    model[6] = 32'h6666_6666; model[7] = 32'h7777_7777;
    dbg_peek(4'd6, v); check("R10 core slot written", v, model[6]);
    dbg_peek(4'd7, v); check("R10 debug slot written", v, model[7]);
  endtask

  task automatic t_rd_during_wr();
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_field = 4'd3;
    dbg_we = 1'b1; dbg_idx = 4'd3; dbg_wdata = 32'h3333_CAFE;
    @(negedge clk);
    req_valid = 1'b0; dbg_we = 1'b0;
    check("R11 read returns old value", resp_rdata, model[3]);
    model[3] = 32'h3333_CAFE;
    dbg_peek(4'd3, v); check("R11 write landed", v, model[3]);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_field = 4'd2;
    @(negedge clk);
    req_op = 2'd3; req_field = 4'd5;
    check("R8 first answer", {resp_valid, resp_cant, resp_rdata[30:0]}, {2'b10, model[2][30:0]});
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second answer", {29'd0, resp_valid, resp_done, resp_cant}, 32'h5);
    @(negedge clk);
    check("R8 no answer without request", {29'd0, resp_valid, resp_done, resp_cant}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_core_rw();
    t_index_mask();
    t_id();
    t_cfg();
    t_cant();
    t_dbg_oob();
    t_collide();
    t_rd_during_wr();
    t_back_to_back();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=hung expected=completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule